// File: doc/BRIEF.md
# Lockable Peripheral Clock Channel Registers

This block holds one small control register per peripheral clock channel of a generic clock controller. Each register picks the clock generator that feeds its channel and turns the channel on or off. A sticky lock bit freezes the register. While a locked register selects a generator other than generator 0, the block also raises that generator's lock request, so the generator's own control register refuses writes.

Software reaches the registers through a simple write/read port on the bus clock. The enable bit crosses into the peripheral clock domain through a two-flop handshake with an acknowledge back. The readable enable shows only the acknowledged state, so software polls it until the new value appears. Two resets are provided. Power reset clears everything. User reset clears only the channels that are not locked.

Top module: `pclk_chan_regs`

## Requirements
- R1: After power reset every channel register reads 0x00000000, and all `ch_en`, `ch_gen` and `gen_lock_req` outputs are zero.
- R2: Channel m sits at byte address 0x80 + 4*m for m = 0..NUM_CH-1. Bits [2:0] hold the generator select, bit 6 holds the enable and bit 7 holds the lock. All other read bits are zero and written values in them are dropped.
- R3: A write whose generator field is 5, 6 or 7 leaves the stored generator select unchanged. The enable and lock bits of that write still take effect.
- R4: Once a channel's lock bit is 1, writes to that channel change nothing.
- R5: `gen_lock_req[g]` for g >= 1 is 1 exactly when at least one locked channel selects generator g.
- R6: `gen_lock_req[0]` stays 0, even while a locked channel selects generator 0.
- R7: A one-cycle `usr_rst` pulse clears the generator select and the enable of every unlocked channel. Locked channels, lock bits included, keep their contents.
- R8: Power reset clears all fields of all channels, lock bits included, so the channels accept writes again afterwards.
- R9: After a change to the enable, the enable bit read back keeps the old value until the handshake through the peripheral domain completes. It then shows the new value, and `ch_en` already carries that value. The whole exchange takes fewer than 40 bus cycles when the peripheral clock is at least a third of the bus clock rate.
- R10: Reads at addresses that are not word-aligned or that lie outside the channel range return zero. Writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| pclk | input | 1 | Peripheral domain clock |
| pwr_rst_n | input | 1 | Power reset, asynchronous, active low |
| usr_rst | input | 1 | User reset, one bus-cycle pulse, active high |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| ch_en | output | NUM_CH | Per-channel enable in the peripheral domain |
| ch_gen | output | NUM_CH*GEN_W | Per-channel generator select, channel m at [m*GEN_W +: GEN_W] |
| gen_lock_req | output | NUM_GEN | Per-generator lock request |

## Verification
A stored field that goes wrong appears on `rdata` as soon as the bench reads that channel's address, one cycle after the write. A wrong generator select appears on `ch_gen` in the same cycle. A lock bit that is lost or set by mistake shows up at once on `gen_lock_req`, or later on the next write, when that write is either refused when it should land or lands when it should be refused. A fault in the enable handshake only becomes visible over the polling window: the read-back either changes too early or never changes, and `ch_en` disagrees with the value read back once the poll ends.

// File: rtl/pclk_chan_regs.sv
module pclk_chan_regs #(
  parameter int NUM_CH  = 21,
  parameter int NUM_GEN = 5,
  parameter int ADDR_W  = 8,
  parameter int BASE    = 'h80
) (
  input  logic                      clk,
  input  logic                      pclk,
  input  logic                      pwr_rst_n,
  input  logic                      usr_rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  output logic [NUM_CH-1:0]         ch_en,
  output logic [NUM_CH*3-1:0]       ch_gen,
  output logic [NUM_GEN-1:0]        gen_lock_req
);
  localparam int GEN_W  = 3;
  localparam int IDX_W  = $clog2(NUM_CH);
  localparam int EN_BIT = 6;
  localparam int LK_BIT = 7;

  logic [GEN_W-1:0]  gen_q [NUM_CH];
  logic [NUM_CH-1:0] req_q, lock_q, ack_s1, ack_q, p_s1, p_s2;
  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  idx;
  logic              hit;
  logic              gen_ok;

  assign off    = addr - ADDR_W'(BASE);
  assign hit    = (addr >= ADDR_W'(BASE)) && (addr < ADDR_W'(BASE + 4*NUM_CH)) && (addr[1:0] == 2'b00);
  assign idx    = off[IDX_W+1:2];
  assign gen_ok = {1'b0, wdata[GEN_W-1:0]} < (GEN_W+1)'(NUM_GEN);
  assign ch_en  = p_s2;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk or negedge pwr_rst_n) begin
      if (!pwr_rst_n) begin
        gen_q[i]  <= '0;
        req_q[i]  <= 1'b0;
        lock_q[i] <= 1'b0;
      end else if (usr_rst) begin
        if (!lock_q[i]) begin
          gen_q[i] <= '0;
          req_q[i] <= 1'b0;
        end
      end else if (wr_en && hit && idx == IDX_W'(i) && !lock_q[i]) begin
        if (gen_ok) gen_q[i] <= wdata[GEN_W-1:0];
        req_q[i]  <= wdata[EN_BIT];
        lock_q[i] <= wdata[LK_BIT];
      end
    end
    assign ch_gen[i*GEN_W +: GEN_W] = gen_q[i];

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      lock_q[i] |=> lock_q[i]);                                            // R4
    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      lock_q[i] |=> ($stable(gen_q[i]) && $stable(req_q[i])));             // R7
    AST_USR_CLEARS: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (usr_rst && !lock_q[i]) |=> (gen_q[i] == '0 && !req_q[i]));          // R7
    AST_GEN_IN_RANGE: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      {1'b0, gen_q[i]} < (GEN_W+1)'(NUM_GEN));                             // R3
    AST_MISS_NO_EFFECT: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      (wr_en && !usr_rst && !(hit && idx == IDX_W'(i))) |=>
        ($stable(gen_q[i]) && $stable(lock_q[i]) && $stable(req_q[i])));   // R10
  end

  always_ff @(posedge pclk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) begin
      p_s1 <= '0;
      p_s2 <= '0;
    end else begin
      p_s1 <= req_q;
      p_s2 <= p_s1;
    end
  end

  always_ff @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) begin
      ack_s1 <= '0;
      ack_q  <= '0;
    end else begin
      ack_s1 <= p_s2;
      ack_q  <= ack_s1;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[GEN_W-1:0] = gen_q[idx];
      rdata[EN_BIT]    = ack_q[idx];
      rdata[LK_BIT]    = lock_q[idx];
    end
  end

  always_comb begin
    gen_lock_req = '0;
    for (int g = 1; g < NUM_GEN; g++)
      for (int c = 0; c < NUM_CH; c++)
        if (lock_q[c] && gen_q[c] == GEN_W'(g)) gen_lock_req[g] = 1'b1;
  end

  AST_GEN0_NEVER_LOCKED: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (|lock_q) |-> !gen_lock_req[0]);                                       // R6
endmodule

// File: tb/pclk_chan_regs_bench.sv
module pclk_chan_regs_bench;
  localparam int NUM_CH = 21;
  localparam int NUM_GEN = 5;

  logic clk = 1'b0, pclk = 1'b0;
  logic pwr_rst_n = 1'b0, usr_rst = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NUM_CH-1:0]   ch_en;
  logic [NUM_CH*3-1:0] ch_gen;
  logic [NUM_GEN-1:0]  gen_lock_req;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always #10 pclk = ~pclk;

  pclk_chan_regs u_pclk_chan_regs (
    .clk(clk), .pclk(pclk), .pwr_rst_n(pwr_rst_n), .usr_rst(usr_rst),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ch_en(ch_en), .ch_gen(ch_gen), .gen_lock_req(gen_lock_req)
  );

  // {address, write data, expected read-back}
  localparam logic [71:0] VEC [8] = '{
    {8'h80, 32'h0000_0003, 32'h0000_0003},
    {8'h84, 32'h0000_0004, 32'h0000_0004},
    {8'hD0, 32'h0000_0002, 32'h0000_0002},
    {8'h80, 32'h0000_0007, 32'h0000_0003},
    {8'h84, 32'h0000_0005, 32'h0000_0004},
    {8'h88, 32'h0000_0001, 32'h0000_0001},
    {8'h88, 32'hFFFF_FF31, 32'h0000_0001},
    {8'hD0, 32'h0000_0006, 32'h0000_0002}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic poll_en(input logic [7:0] a, input logic v, output logic [31:0] d);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      rd(a, d);
      if (d[6] == v) break;
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    pwr_rst_n = 1'b1;
    @(negedge clk);
    rd(8'h80, d); check("R1 ch0 reset", d, 32'h0);
    rd(8'hD0, d); check("R1 ch20 reset", d, 32'h0);
    check("R1 outputs", {ch_en, gen_lock_req}, '0);
    check("R1 ch_gen", 32'(ch_gen == '0), 32'd1);

    for (int v = 0; v < 8; v++) begin
      wr(VEC[v][71:64], VEC[v][63:32]);
      rd(VEC[v][71:64], d);
      check("R2/R3 vector", d, VEC[v][31:0]);
    end
    check("R2 ch_gen ch1", 32'(ch_gen[3 +: 3]), 32'd4);
    check("R2 ch_gen ch20", 32'(ch_gen[60 +: 3]), 32'd2);

    wr(8'h84, 32'h0000_0047);
    rd(8'h84, d); check("R3 bad gen, enable applied later", d, 32'h0000_0004);

    wr(8'h80, 32'h0000_0043);
    rd(8'h80, d); check("R9 pending shows old", d, 32'h0000_0003);
    poll_en(8'h80, 1'b1, d);
    check("R9 enable completes", d, 32'h0000_0043);
    check("R9 ch_en follows", 32'(ch_en[0]), 32'd1);
    poll_en(8'h84, 1'b1, d);
    check("R3 enable of bad-gen write", d, 32'h0000_0044);

    wr(8'h86, 32'h0000_0041);
    rd(8'h84, d); check("R10 unaligned write dropped", d, 32'h0000_0044);
    rd(8'h86, d); check("R10 unaligned read", d, 32'h0);
    wr(8'hD4, 32'h0000_0081);
    rd(8'hD4, d); check("R10 past range read", d, 32'h0);
    rd(8'h7C, d); check("R10 below range read", d, 32'h0);
    check("R10 no lock from stray write", 32'(gen_lock_req), 32'h0);

    wr(8'h88, 32'h0000_0081);
    check("R5 gen1 lock request", 32'(gen_lock_req), 32'h02);
    wr(8'h88, 32'h0000_0003);
    rd(8'h88, d); check("R4 locked write ignored", d, 32'h0000_0081);
    wr(8'h8C, 32'h0000_0080);
    rd(8'h8C, d); check("R6 ch3 locked on gen0", d, 32'h0000_0080);
    check("R6 gen0 not requested", 32'(gen_lock_req), 32'h02);
    wr(8'h90, 32'h0000_0084);
    check("R5 gen4 joins", 32'(gen_lock_req), 32'h12);

    @(negedge clk); usr_rst = 1'b1;
    @(negedge clk); usr_rst = 1'b0;
    rd(8'h80, d); check("R7 unlocked gen cleared, ack pending", d, 32'h0000_0040);
    poll_en(8'h80, 1'b0, d);
    check("R7 unlocked channel cleared", d, 32'h0);
    check("R7 ch_en dropped", 32'(ch_en[0]), 32'd0);
    rd(8'h88, d); check("R7 locked channel kept", d, 32'h0000_0081);
    rd(8'h90, d); check("R7 locked channel kept ch4", d, 32'h0000_0084);
    check("R7 lock requests kept", 32'(gen_lock_req), 32'h12);

    @(negedge clk); pwr_rst_n = 1'b0;
    @(negedge clk); pwr_rst_n = 1'b1;
    rd(8'h88, d); check("R8 locked channel cleared", d, 32'h0);
    check("R8 lock requests released", 32'(gen_lock_req), 32'h0);
    wr(8'h88, 32'h0000_0002);
    rd(8'h88, d); check("R8 writes accepted again", d, 32'h0000_0002);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule